// File: doc/BRIEF.md
# Card Host Interrupt Status and Enable Unit

This unit gathers the event pulses raised by the command, data, buffer and card-detect logic of a memory-card host controller. It stores them in a 32-bit status register and masks them with a 19-bit enable register. It drives one interrupt line whenever an enabled event is pending. Most status flags are sticky: an event pulse sets them, and software clears them by writing a 1 to the flag. Six buffer-state flags instead mirror live levels and cannot be cleared by writing.

A write-CRC failure also records the card's 2-bit CRC status token in a code field. The unit provides two further outputs. An error summary is high when any of the five error flags is set. A wakeup output is driven by three separate wakeup enables. Software reads both registers continuously on two read ports and writes them through a single write strobe with a one-bit register select.

Top module: `hirq_unit`

## Requirements
- R1: After reset the status readback, the enable readback, `irq`, `err_any` and `wake` are all 0.
- R2: The sticky flags sit at status bits 31 (inserted), 30 (removed), 25 (underrun), 24 (overflow), 14 (SDIO), 13 (command end), 12 (write done), 11 (read done), 5, 3, 2, 1 and 0. A 1 on the same bit of `ev_set` sets the flag. The flag is visible one cycle later and stays set until it is cleared.
- R3: A write with `reg_addr`=0 clears every sticky flag whose `reg_wdata` bit is 1. Flags whose `reg_wdata` bit is 0 are left unchanged.
- R4: When an `ev_set` bit and a write-1 clear hit the same sticky flag in the same cycle, the flag ends up set.
- R5: Status bits 29, 28, 27, 26, 7 and 6 show the value `lvl_in` had at the previous clock edge. Writes to these bits have no effect.
- R6: When `ev_set[2]` is 1 (write CRC error), status bits [10:9] load `crc_tok`, where the value 2 means the card gave no CRC response. Clearing bit 2 also zeroes [10:9]. Writes to [10:9] are ignored. Bits 23:15, 8 and 4 always read 0.
- R7: A write with `reg_addr`=1 loads the enable register. Only bits 18:12 and 4:0 are writable; bits 11:5 read 0.
- R8: `irq` is 1 exactly when one of these enable/source pairs has both members set: en15/st31, en14/st30, en13/st14, en12/`dat0_lvl`, en4/st7, en3/st6, en2/st13, en1/st12, en0/st11.
- R9: `err_any` is 1 exactly when any of status bits 5, 3, 2, 1, 0 (mask 0x2F) is set.
- R10: `wake` is 1 exactly when one of these pairs has both members set: en18/st14, en17/st31, en16/st30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | 32 | Write data |
| ev_set | input | 32 | Event pulses, one per status bit position |
| lvl_in | input | 32 | Live buffer levels, one per status bit position |
| crc_tok | input | 2 | CRC status token captured on a write CRC error |
| dat0_lvl | input | 1 | Data line 0 level used as an interrupt source |
| stat_rdata | output | 32 | Status register readback |
| enab_rdata | output | 19 | Enable register readback |
| irq | output | 1 | Interrupt request |
| err_any | output | 1 | Any error flag set |
| wake | output | 1 | Wakeup request |

## Verification
Every status and enable change becomes visible one cycle after the clock edge that captures the stimulus. `irq`, `err_any` and `wake` depend only on the registered state, plus the `dat0_lvl` level, so they settle in that same cycle. The bench drives each stimulus on a falling edge and samples on the next falling edge, so exactly one capturing edge lies between them. It then removes the stimulus before checking that sticky state holds. The code field, the set-versus-clear collision and the non-clearable live bits are each sampled at that same one-cycle point.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
    localparam int STAT_W   = 32;
    localparam int EN_W     = 19;
    localparam int CODE_W   = 2;
    localparam int CODE_LO  = 9;
    localparam int WCRC_BIT = 2;

    // Bit classes of the status register
    localparam logic [STAT_W-1:0] STICKY_M = 32'hC300_782F;
    localparam logic [STAT_W-1:0] LIVE_M   = 32'h3C00_00C0;
    localparam logic [STAT_W-1:0] ERR_M    = 32'h0000_002F;
    localparam logic [EN_W-1:0]   EN_M     = 19'h7_F01F;

    // Interrupt pairs: status source bit and enable bit
    localparam int N_IRQ    = 9;
    localparam int DAT0_IDX = 3;
    localparam int IRQ_ST [N_IRQ] = '{31, 30, 14, 0, 7, 6, 13, 12, 11};
    localparam int IRQ_EN [N_IRQ] = '{15, 14, 13, 12, 4, 3, 2, 1, 0};

    // Wakeup pairs
    localparam int N_WAKE = 3;
    localparam int WK_ST [N_WAKE] = '{14, 31, 30};
    localparam int WK_EN [N_WAKE] = '{18, 17, 16};

    typedef struct packed {
        logic [STAT_W-1:0] bits;
        logic [CODE_W-1:0] code;
    } stat_st_t;

    typedef struct packed {
        logic [EN_W-1:0] en;
    } en_st_t;
endpackage

// File: rtl/hirq_status.sv
module hirq_status
    import hirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [STAT_W-1:0] wdata,
    input  logic [STAT_W-1:0] ev_set,
    input  logic [STAT_W-1:0] lvl_in,
    input  logic [CODE_W-1:0] crc_tok,
    output logic [STAT_W-1:0] stat_q
);
    stat_st_t s_d, s_q;
    logic [STAT_W-1:0] clr_vec;

    assign clr_vec = clr_en ? wdata : '0;

    always_comb begin
        s_d = s_q;
        for (int b = 0; b < STAT_W; b++) begin
            if (STICKY_M[b]) begin
                s_d.bits[b] = ev_set[b] | (s_q.bits[b] & ~clr_vec[b]);
            end else if (LIVE_M[b]) begin
                s_d.bits[b] = lvl_in[b];
            end else begin
                s_d.bits[b] = 1'b0;
            end
        end
        if (ev_set[WCRC_BIT]) begin
            s_d.code = crc_tok;
        end else if (clr_vec[WCRC_BIT]) begin
            s_d.code = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        stat_q = s_q.bits;
        stat_q[CODE_LO +: CODE_W] = s_q.code;
    end

    logic unused_in_bits;
    assign unused_in_bits = ^{ev_set & ~STICKY_M, lvl_in & ~LIVE_M, wdata & ~STICKY_M};

    for (genvar b = 0; b < STAT_W; b++) begin : g_chk
        if (STICKY_M[b]) begin : g_sticky
            // R2
            sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ev_set[b] |=> stat_q[b]);
            // R3
            sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_en && wdata[b] && !ev_set[b]) |=> !stat_q[b]);
            // R3
            sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ev_set[b] && !(clr_en && wdata[b])) |=> $stable(stat_q[b]));
        end else if (LIVE_M[b]) begin : g_live
            // R5
            live_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (stat_q[b] == $past(lvl_in[b])));
        end
    end

    // R6
    code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_set[WCRC_BIT] |=> (stat_q[CODE_LO +: CODE_W] == $past(crc_tok)));
endmodule

// File: rtl/hirq_enable.sv
module hirq_enable
    import hirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [EN_W-1:0] wdata,
    output logic [EN_W-1:0] en_q
);
    en_st_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (wr_en) begin
            e_d.en = wdata & EN_M;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign en_q = e_q.en;

    // R7
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == ($past(wdata) & EN_M)));
endmodule

// File: rtl/hirq_combine.sv
module hirq_combine
    import hirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat,
    input  logic [EN_W-1:0]   en,
    input  logic              dat0_lvl,
    output logic              irq,
    output logic              err_any,
    output logic              wake
);
    logic [N_IRQ-1:0]  hit;
    logic [N_WAKE-1:0] wk_hit;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
        if (i == DAT0_IDX) begin : g_dat0
            assign hit[i] = dat0_lvl & en[IRQ_EN[i]];
        end else begin : g_flag
            assign hit[i] = stat[IRQ_ST[i]] & en[IRQ_EN[i]];
        end
    end

    for (genvar i = 0; i < N_WAKE; i++) begin : g_wake
        assign wk_hit[i] = stat[WK_ST[i]] & en[WK_EN[i]];
    end

    assign irq     = |hit;
    assign wake    = |wk_hit;
    assign err_any = |(stat & ERR_M);

    logic unused_pair_bits;
    assign unused_pair_bits = ^{stat, en};

    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en[15:12] != 4'd0 || en[4:0] != 5'd0));
    // R10
    wake_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (en[18:16] != 3'd0));
    // R9
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |-> (stat[5:0] & 6'h2F) != 6'd0);
endmodule

// File: rtl/hirq_unit.sv
module hirq_unit
    import hirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [STAT_W-1:0] reg_wdata,
    input  logic [STAT_W-1:0] ev_set,
    input  logic [STAT_W-1:0] lvl_in,
    input  logic [CODE_W-1:0] crc_tok,
    input  logic              dat0_lvl,
    output logic [STAT_W-1:0] stat_rdata,
    output logic [EN_W-1:0]   enab_rdata,
    output logic              irq,
    output logic              err_any,
    output logic              wake
);
    logic stat_wr, en_wr;

    assign stat_wr = reg_wr & ~reg_addr;
    assign en_wr   = reg_wr &  reg_addr;

    hirq_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (stat_wr),
        .wdata   (reg_wdata),
        .ev_set  (ev_set),
        .lvl_in  (lvl_in),
        .crc_tok (crc_tok),
        .stat_q  (stat_rdata)
    );

    hirq_enable u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (en_wr),
        .wdata (reg_wdata[EN_W-1:0]),
        .en_q  (enab_rdata)
    );

    hirq_combine u_combine (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat     (stat_rdata),
        .en       (enab_rdata),
        .dat0_lvl (dat0_lvl),
        .irq      (irq),
        .err_any  (err_any),
        .wake     (wake)
    );
endmodule

// File: tb/hirq_unit_tb_top.sv
module hirq_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] ev_set = '0;
    logic [31:0] lvl_in = '0;
    logic [1:0]  crc_tok = '0;
    logic        dat0_lvl = 1'b0;
    logic [31:0] stat_rdata;
    logic [18:0] enab_rdata;
    logic        irq, err_any, wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] sticky_m, live_m;
    logic [31:0] irq_src_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    hirq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ev_set(ev_set), .lvl_in(lvl_in),
        .crc_tok(crc_tok), .dat0_lvl(dat0_lvl), .stat_rdata(stat_rdata),
        .enab_rdata(enab_rdata), .irq(irq), .err_any(err_any), .wake(wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        automatic int st_list [13] = '{31, 30, 25, 24, 14, 13, 12, 11, 5, 3, 2, 1, 0};
        automatic int lv_list [6]  = '{29, 28, 27, 26, 7, 6};
        automatic int pst [9] = '{31, 30, 14, -1, 7, 6, 13, 12, 11};
        automatic int pen [9] = '{15, 14, 13, 12, 4, 3, 2, 1, 0};
        logic [18:0] en_all;
        sticky_m = '0; live_m = '0;
        foreach (st_list[k]) sticky_m[st_list[k]] = 1'b1;
        foreach (lv_list[k]) live_m[lv_list[k]] = 1'b1;
        irq_src_m = (32'd1 << 31) | (32'd1 << 30) | (32'd1 << 14) | (32'd1 << 13)
                  | (32'd1 << 12) | (32'd1 << 11) | (32'd1 << 7) | (32'd1 << 6);
        en_all = 19'h7F000 | 19'h1F;

        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 status", stat_rdata, 0);
        chk("R1 enable", {13'd0, enab_rdata}, 0);
        chk("R1 outs", {29'd0, irq, err_any, wake}, 0);

        // R7 enable writable bits
        wr(1'b1, 32'hFFFF_FFFF);
        step();
        chk("R7 enable mask", {13'd0, enab_rdata}, {13'd0, en_all});

        // R2/R3/R6/R8/R9/R10 sweep every status position with a pulse
        for (int b = 0; b < 32; b++) begin
            logic [31:0] exp_s;
            exp_s = sticky_m & (32'd1 << b);
            ev_set = 32'd1 << b;
            step();
            ev_set = '0;
            step();
            chk($sformatf("R2 set bit %0d", b), stat_rdata, exp_s);
            chk($sformatf("R8 irq bit %0d", b), {31'd0, irq}, {31'd0, |(exp_s & irq_src_m)});
            chk($sformatf("R9 err bit %0d", b), {31'd0, err_any}, {31'd0, |(exp_s & 32'h2F)});
            chk($sformatf("R10 wake bit %0d", b), {31'd0, wake},
                {31'd0, |(exp_s & ((32'd1 << 14) | (32'd1 << 31) | (32'd1 << 30)))});
            wr(1'b0, ~(32'd1 << b));
            chk($sformatf("R3 zero-write bit %0d", b), stat_rdata, exp_s);
            wr(1'b0, 32'd1 << b);
            chk($sformatf("R3 clear bit %0d", b), stat_rdata, 0);
        end

        // R3 write 0 leaves all sticky flags
        ev_set = '1; step(); ev_set = '0;
        crc_tok = 2'd0;
        wr(1'b0, 32'd0);
        chk("R3 write zero keeps all", stat_rdata, sticky_m);
        // R4 set wins over clear in same cycle
        ev_set = 32'd1 << 13; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = '1;
        step();
        ev_set = '0; reg_wr = 1'b0; reg_wdata = '0;
        chk("R4 set wins", stat_rdata, 32'd1 << 13);
        wr(1'b0, '1);
        chk("R3 clear all", stat_rdata, 0);

        // R5 live bits follow levels, writes ignored
        foreach (lv_list[k]) begin
            lvl_in = 32'd1 << lv_list[k];
            step();
            chk($sformatf("R5 live bit %0d", lv_list[k]), stat_rdata, 32'd1 << lv_list[k]);
            chk($sformatf("R8 irq live %0d", lv_list[k]), {31'd0, irq},
                {31'd0, |(irq_src_m & (32'd1 << lv_list[k]))});
            wr(1'b0, '1);
            chk($sformatf("R5 write ignored %0d", lv_list[k]), stat_rdata, 32'd1 << lv_list[k]);
            lvl_in = '0;
            step();
            chk($sformatf("R5 live drop %0d", lv_list[k]), stat_rdata, 0);
        end

        // R6 CRC token code field
        for (int t = 0; t < 4; t++) begin
            crc_tok = t[1:0];
            ev_set = 32'd4;
            step();
            ev_set = '0; crc_tok = 2'd0;
            chk($sformatf("R6 code load %0d", t), stat_rdata, 32'd4 | (t << 9));
            wr(1'b0, 32'h600);
            chk($sformatf("R6 code write ignored %0d", t), stat_rdata, 32'd4 | (t << 9));
            wr(1'b0, 32'd4);
            chk($sformatf("R6 code cleared %0d", t), stat_rdata, 0);
        end

        // R8 each interrupt pair alone, and blocked when only others enabled
        for (int i = 0; i < 9; i++) begin
            wr(1'b1, 32'd1 << pen[i]);
            if (pst[i] < 0) dat0_lvl = 1'b1;
            else if (live_m[pst[i]]) lvl_in = 32'd1 << pst[i];
            else ev_set = 32'd1 << pst[i];
            step();
            ev_set = '0;
            step();
            chk($sformatf("R8 pair %0d on", i), {31'd0, irq}, 32'd1);
            wr(1'b1, {13'd0, en_all & ~(19'd1 << pen[i])} & ~32'h70000);
            chk($sformatf("R8 pair %0d masked", i), {31'd0, irq}, 0);
            dat0_lvl = 1'b0; lvl_in = '0;
            wr(1'b0, '1);
            wr(1'b1, 0);
            chk($sformatf("R8 pair %0d off", i), {31'd0, irq}, 0);
        end

        // R10 wake with only wake enables
        wr(1'b1, 32'h70000);
        ev_set = 32'd1 << 30; step(); ev_set = '0; step();
        chk("R10 wake removal", {30'd0, wake, irq}, 32'd2);
        wr(1'b1, 32'h60000);
        chk("R10 wake masked", {31'd0, wake}, 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule